// File: doc/BRIEF.md
# Stereo Audio Serial Transmitter

This block takes 32-bit words from a ready/valid input and sends them, most significant bit first, on a single serial data line. The line carries two channels, left and right, which alternate in halves of a frame marked by a word-select signal. Data changes on the falling edge of a bit clock, so a receiver can capture it on the rising edge. The bit clock and word select come from one of two places. In master mode the block makes them by dividing the system clock. In slave mode it takes them from input pins and resynchronises them.

Two framings are supported. In the first, the left half is marked by word select low and each sample begins one bit period after the word-select edge. In the second, the left half is marked by word select high and each sample begins on the edge itself. A 3-bit length code picks the sample width. Two of the codes pack both channels into one word. A mono option sends one sample in both halves. When no word is waiting at the start of a slot, the block raises an underrun flag and marks which channel was hit. It then sends either zeros or a repeat of that channel's previous sample.

The framing controller is a three-state machine. The states are FR_WAIT (no frame seen since reset), FR_LEFT and FR_RIGHT. FR_WAIT goes to FR_LEFT on the first bit-clock fall in master mode, or in slave mode on the first word-select change into the left level. FR_LEFT and FR_RIGHT hand over to each other at every slot boundary. In master mode a boundary comes after a slot-width count of bit clocks. In slave mode it comes when the synchronised word select changes.

Top module: `stereo_ser_tx`

## Requirements
- R1: With `cfg_lj`=0 the left slot has `ws_o` low. The MSB of each sample is on the line in the bit period after the `ws_o` change, and the sample's LSB falls in the first bit period of the following slot when the slot width equals the sample length.
- R2: With `cfg_lj`=1 the left slot has `ws_o` high, and the MSB is on the line in the same bit period as the `ws_o` change.
- R3: `cfg_len` gives the sample length: 0=32, 1=24, 2=20, 3=18, 4=16, 5=16 packed, 6=8, 7=8 packed. A sample is the low-order length bits of the word. It is sent MSB first, and the line is held at 0 from the bit after the LSB to the end of the slot.
- R4: With `cfg_slot32`=1 each half of the word-select period is 32 bit clocks. With `cfg_slot32`=0 it equals the sample length, which is 16 or 8 for the packed codes.
- R5: With code 5 or 7, one word feeds a whole frame. The left slot sends bits 15:0 (or 7:0) and the right slot sends bits 31:16 (or 15:8).
- R6: With `cfg_mono`=1 (and no packed code), one word feeds a whole frame and the same sample is sent in both slots.
- R7: A slot that finds no data sets `ur_flag` together with a channel bit in `ur_chan` (bit 0 left, bit 1 right). The flag and bits hold until `ur_clr`. If a new underrun and `ur_clr` happen in the same cycle, the set wins.
- R8: On underrun, a slot sends the previous sample of its own channel when `cfg_repeat`=1, and all zeros when `cfg_repeat`=0.
- R9: In master mode `bclk_o` has a period of 2·`cfg_half` system clocks. `ws_o` and `sd_o` change only in the cycle `bclk_o` falls.
- R10: In slave mode `bclk_o` and `ws_o` repeat `ext_bclk` and `ext_ws`. Data is driven after each synchronised falling edge of `ext_bclk`, and slots follow the changes of `ext_ws`.
- R11: The input holds one word, and `in_ready` is low while it is full. Words are used in arrival order: one per slot in plain stereo, and one per frame (at the left slot) in packed or mono mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_master | input | 1 | 1: generate bit clock and word select; 0: take them from ext pins |
| cfg_lj | input | 1 | 0: delayed framing, left low; 1: left-justified, left high |
| cfg_len | input | 3 | Sample length code |
| cfg_mono | input | 1 | Send one sample in both slots |
| cfg_repeat | input | 1 | Underrun policy: 1 repeat previous sample, 0 send zeros |
| cfg_slot32 | input | 1 | 1: 32-bit slots; 0: slot equals sample length |
| cfg_half | input | DIV_W | Bit-clock half period in system clocks (master) |
| ur_clr | input | 1 | Clears the underrun flag and channel bits |
| in_valid | input | 1 | Input word valid |
| in_data | input | 32 | Input word |
| ext_bclk | input | 1 | External bit clock (slave) |
| ext_ws | input | 1 | External word select (slave) |
| in_ready | output | 1 | Holding word is empty |
| bclk_o | output | 1 | Bit clock seen by the line |
| ws_o | output | 1 | Word select seen by the line |
| sd_o | output | 1 | Serial data |
| ur_flag | output | 1 | Sticky underrun flag |
| ur_chan | output | 2 | Sticky per-channel underrun bits |

## Verification
Two events can land in the same cycle: a slot's underrun setting the flag, and a software clear of that flag. One run holds `ur_clr` high for its whole length while the words run out, so every underrun meets a clear. The flag must still be seen high in exactly one cycle per underrun, and never for two cycles in a row. A stuck clear-first priority would hide the flag, and a missing clear would leave it high. A reference receiver in the bench decodes every slot from the pins and compares it with a queue-driven model of the packing, mono and underrun rules.

// File: rtl/stx_pkg.sv
package stx_pkg;

    typedef enum logic [1:0] {
        FR_WAIT  = 2'd0,
        FR_LEFT  = 2'd1,
        FR_RIGHT = 2'd2
    } frame_st_t;

    // Sample length in bits for each length code.
    function automatic logic [5:0] len_bits(input logic [2:0] code);
        logic [5:0] n;
        unique case (code)
            3'd0: n = 6'd32;
            3'd1: n = 6'd24;
            3'd2: n = 6'd20;
            3'd3: n = 6'd18;
            3'd4, 3'd5: n = 6'd16;
            default: n = 6'd8;
        endcase
        return n;
    endfunction

    function automatic logic is_packed(input logic [2:0] code);
        return (code == 3'd5) || (code == 3'd7);
    endfunction

    function automatic logic [31:0] low_mask(input logic [5:0] n);
        return (n >= 6'd32) ? 32'hFFFF_FFFF : ((32'd1 << n) - 32'd1);
    endfunction

endpackage

// File: rtl/stx_bclk.sv
module stx_bclk #(
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             master,
    input  logic [DIV_W-1:0] half,
    input  logic             ext_bclk,
    input  logic             ext_ws,
    output logic             fall_ev,
    output logic             gen_bclk,
    output logic             ws_sync
);
    logic [DIV_W-1:0]     div_q;
    logic                 bclk_q;
    logic [SYNC_STAGES:0] bsync;
    logic [SYNC_STAGES-1:0] wsync;
    logic                 tc;

    assign tc = ({1'b0, div_q} + {{DIV_W{1'b0}}, 1'b1}) >= {1'b0, half};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q  <= '0;
            bclk_q <= 1'b0;
            bsync  <= '0;
            wsync  <= '0;
        end else begin
            bsync <= {bsync[SYNC_STAGES-1:0], ext_bclk};
            wsync <= {wsync[SYNC_STAGES-2:0], ext_ws};
            if (master) begin
                if (tc) begin
                    div_q  <= '0;
                    bclk_q <= ~bclk_q;
                end else begin
                    div_q <= div_q + 1'b1;
                end
            end else begin
                div_q  <= '0;
                bclk_q <= 1'b0;
            end
        end
    end

    assign fall_ev  = master ? (tc && bclk_q)
                             : (bsync[SYNC_STAGES] && !bsync[SYNC_STAGES-1]);
    assign gen_bclk = bclk_q;
    assign ws_sync  = wsync[SYNC_STAGES-1];
endmodule

// File: rtl/stx_frame.sv
module stx_frame
    import stx_pkg::*;
#(
    parameter int CNT_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ev,
    input  logic             master,
    input  logic             lj,
    input  logic [CNT_W-1:0] slot_w,
    input  logic             ws_in,
    output logic             load,
    output logic             load_left,
    output logic             ws_gen
);
    frame_st_t        st, st_nx;
    logic [CNT_W-1:0] cnt, cnt_nx;
    logic             ws_seen;
    logic             ws_edge;
    logic             boundary;
    logic [CNT_W-1:0] lead;

    assign ws_edge  = ws_in != ws_seen;
    assign boundary = master ? (cnt == slot_w - 1'b1) : ws_edge;
    assign lead     = lj ? '0 : CNT_W'(1);

    always_comb begin
        st_nx  = st;
        cnt_nx = cnt;
        if (ev) begin
            unique case (st)
                FR_WAIT: begin
                    if (master || (ws_edge && ws_in == lj)) begin
                        st_nx  = FR_LEFT;
                        cnt_nx = '0;
                    end
                end
                FR_LEFT, FR_RIGHT: begin
                    if (boundary) begin
                        st_nx  = (st == FR_LEFT) ? FR_RIGHT : FR_LEFT;
                        cnt_nx = '0;
                    end else if (cnt != '1) begin
                        cnt_nx = cnt + 1'b1;
                    end
                end
                default: st_nx = FR_WAIT;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st      <= FR_WAIT;
            cnt     <= '0;
            ws_seen <= 1'b0;
        end else begin
            st  <= st_nx;
            cnt <= cnt_nx;
            if (ev) ws_seen <= ws_in;
        end
    end

    always_comb begin
        load      = ev && (st_nx != FR_WAIT) && (cnt_nx == lead);
        load_left = st_nx == FR_LEFT;
        ws_gen    = (st == FR_LEFT) ? lj : ~lj;
    end
endmodule

// File: rtl/stx_feed.sv
module stx_feed
    import stx_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic        load_left,
    input  logic [2:0]  len_code,
    input  logic        mono,
    input  logic        repeat_last,
    input  logic        ur_clr,
    input  logic        in_valid,
    input  logic [31:0] in_data,
    output logic        in_ready,
    output logic [31:0] aligned,
    output logic        ur_flag,
    output logic [1:0]  ur_chan
);
    logic        hold_v, pend_v;
    logic [31:0] hold_q, pend_q, last_l, last_r;
    logic [5:0]  lb;
    logic        packed_m, one_per_frame, consume, take, ur_hit;
    logic [31:0] smp, pend_new, mask;

    always_comb begin
        lb            = len_bits(len_code);
        mask          = low_mask(lb);
        packed_m      = is_packed(len_code);
        one_per_frame = packed_m || mono;
        consume       = load && (load_left || !one_per_frame);
        take          = consume && hold_v;
        pend_new      = packed_m ? ((hold_q >> lb) & mask) : (hold_q & mask);
        if (take)
            smp = hold_q & mask;
        else if (consume)
            smp = repeat_last ? (load_left ? last_l : last_r) : 32'd0;
        else
            smp = pend_v ? pend_q : (repeat_last ? last_r : 32'd0);
        ur_hit  = load && ((consume && !hold_v) || (!consume && !pend_v));
        aligned = smp << (6'd32 - lb);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hold_v  <= 1'b0;
            hold_q  <= '0;
            pend_v  <= 1'b0;
            pend_q  <= '0;
            last_l  <= '0;
            last_r  <= '0;
            ur_flag <= 1'b0;
            ur_chan <= 2'b00;
        end else begin
            if (take) begin
                hold_v <= 1'b0;
            end else if (in_valid && !hold_v) begin
                hold_v <= 1'b1;
                hold_q <= in_data;
            end
            if (load && load_left && one_per_frame) begin
                pend_v <= take;
                pend_q <= pend_new;
            end else if (load && !consume) begin
                pend_v <= 1'b0;
            end
            if (load) begin
                if (load_left) last_l <= smp;
                else           last_r <= smp;
            end
            ur_flag    <= ur_hit | (ur_flag & ~ur_clr);
            ur_chan[0] <= (ur_hit && load_left)  | (ur_chan[0] & ~ur_clr);
            ur_chan[1] <= (ur_hit && !load_left) | (ur_chan[1] & ~ur_clr);
        end
    end

    assign in_ready = !hold_v;
endmodule

// File: rtl/stereo_ser_tx.sv
module stereo_ser_tx
    import stx_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_master,
    input  logic             cfg_lj,
    input  logic [2:0]       cfg_len,
    input  logic             cfg_mono,
    input  logic             cfg_repeat,
    input  logic             cfg_slot32,
    input  logic [DIV_W-1:0] cfg_half,
    input  logic             ur_clr,
    input  logic             in_valid,
    input  logic [31:0]      in_data,
    input  logic             ext_bclk,
    input  logic             ext_ws,
    output logic             in_ready,
    output logic             bclk_o,
    output logic             ws_o,
    output logic             sd_o,
    output logic             ur_flag,
    output logic [1:0]       ur_chan
);
    localparam int CNT_W = 6;

    logic             fall_ev, gen_bclk, ws_sync;
    logic             load, load_left, ws_gen;
    logic [31:0]      aligned, sh;
    logic [CNT_W-1:0] slot_w;

    assign slot_w = cfg_slot32 ? CNT_W'(32) : len_bits(cfg_len);

    stx_bclk #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_bclk (
        .clk(clk), .rst_n(rst_n), .master(cfg_master), .half(cfg_half),
        .ext_bclk(ext_bclk), .ext_ws(ext_ws),
        .fall_ev(fall_ev), .gen_bclk(gen_bclk), .ws_sync(ws_sync)
    );

    stx_frame #(.CNT_W(CNT_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .ev(fall_ev), .master(cfg_master),
        .lj(cfg_lj), .slot_w(slot_w), .ws_in(ws_sync),
        .load(load), .load_left(load_left), .ws_gen(ws_gen)
    );

    stx_feed u_feed (
        .clk(clk), .rst_n(rst_n), .load(load), .load_left(load_left),
        .len_code(cfg_len), .mono(cfg_mono), .repeat_last(cfg_repeat),
        .ur_clr(ur_clr), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .aligned(aligned),
        .ur_flag(ur_flag), .ur_chan(ur_chan)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh   <= '0;
            sd_o <= 1'b0;
        end else if (fall_ev) begin
            if (load) begin
                sd_o <= aligned[31];
                sh   <= aligned << 1;
            end else begin
                sd_o <= sh[31];
                sh   <= sh << 1;
            end
        end
    end

    assign bclk_o = cfg_master ? gen_bclk : ext_bclk;
    assign ws_o   = cfg_master ? ws_gen   : ext_ws;
endmodule

// File: rtl/stx_checker.sv
module stx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       cfg_master,
    input logic       in_valid,
    input logic       in_ready,
    input logic       bclk_o,
    input logic       ws_o,
    input logic       sd_o,
    input logic       ur_flag,
    input logic [1:0] ur_chan
);
    assert_hold_full_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> !in_ready);

    assert_ws_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && !$stable(ws_o)) |-> $fell(bclk_o));

    assert_sd_on_fall_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_master && !$stable(sd_o)) |-> $fell(bclk_o));

    assert_flag_has_chan_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ur_flag |-> (ur_chan != 2'b00));

    assert_chan_has_flag_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ur_chan != 2'b00) |-> ur_flag);
endmodule

bind stereo_ser_tx stx_checker u_chk (
    .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master),
    .in_valid(in_valid), .in_ready(in_ready), .bclk_o(bclk_o),
    .ws_o(ws_o), .sd_o(sd_o), .ur_flag(ur_flag), .ur_chan(ur_chan)
);

// File: tb/tb_stereo_ser_tx.sv
module tb_stereo_ser_tx;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n = 1'b0;
    logic cfg_master, cfg_lj, cfg_mono, cfg_repeat, cfg_slot32, ur_clr;
    logic [2:0] cfg_len;
    logic [7:0] cfg_half;
    logic in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic ext_bclk = 1'b0, ext_ws = 1'b0;
    logic in_ready, bclk_o, ws_o, sd_o, ur_flag;
    logic [1:0] ur_chan;

    stereo_ser_tx dut (
        .clk(clk), .rst_n(rst_n), .cfg_master(cfg_master), .cfg_lj(cfg_lj),
        .cfg_len(cfg_len), .cfg_mono(cfg_mono), .cfg_repeat(cfg_repeat),
        .cfg_slot32(cfg_slot32), .cfg_half(cfg_half), .ur_clr(ur_clr),
        .in_valid(in_valid), .in_data(in_data), .ext_bclk(ext_bclk),
        .ext_ws(ext_ws), .in_ready(in_ready), .bclk_o(bclk_o), .ws_o(ws_o),
        .sd_o(sd_o), .ur_flag(ur_flag), .ur_chan(ur_chan)
    );

    int checks = 0, fails = 0;
    bit wd_hit = 0;
    bit active = 0;

    // model and receiver state
    logic [31:0] wq[$];
    logic [31:0] m_last_l, m_last_r, m_pend;
    bit m_pendv, exp_ur_seen, ur_seen, ur_flag_seen;
    logic [1:0] exp_ur_first, ur_first;
    int fed, k_words, slots_done, slot_width, ecnt, ebit;
    int cyc_since, period, flag_run, flag_run_max;
    bit bprev, ws_hist, cur_lvl, started, rdy_last;
    logic [63:0] bits;
    int nbits;

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int mlen(input logic [2:0] c);
        case (c)
            3'd0: return 32;
            3'd1: return 24;
            3'd2: return 20;
            3'd3: return 18;
            3'd4, 3'd5: return 16;
            default: return 8;
        endcase
    endfunction

    function automatic logic [63:0] mk(input int n);
        return (n >= 64) ? '1 : ((64'd1 << n) - 64'd1);
    endfunction

    function automatic logic [31:0] word_of(input int i);
        return 32'h9E37_79B9 * (i + 3) ^ 32'h5A0F_C3A5;
    endfunction

    task automatic note_ur(input bit left);
        if (!exp_ur_seen) begin
            exp_ur_seen  = 1;
            exp_ur_first = left ? 2'b01 : 2'b10;
        end
    endtask

    // Decode one finished slot and compare it with the model.
    task automatic finish_slot(input bit lvl);
        bit left, pk, consume, urun;
        int ln;
        logic [31:0] w, e;
        logic [63:0] got, tail;
        string tag;
        left    = (lvl == cfg_lj);
        pk      = (cfg_len == 3'd5) || (cfg_len == 3'd7);
        consume = left || !(pk || cfg_mono);
        ln      = mlen(cfg_len);
        urun    = 0;
        if (consume) begin
            if (wq.size() > 0) begin
                w = wq.pop_front();
                e = w & mk(ln);
                if (left && (pk || cfg_mono)) begin
                    m_pend  = pk ? (32'(w >> ln) & 32'(mk(ln))) : e;
                    m_pendv = 1;
                end
            end else begin
                urun = 1;
                e = cfg_repeat ? (left ? m_last_l : m_last_r) : 32'd0;
                note_ur(left);
                if (left) m_pendv = 0;
            end
        end else begin
            if (m_pendv) e = m_pend;
            else begin
                urun = 1;
                e = cfg_repeat ? m_last_r : 32'd0;
                note_ur(0);
            end
            m_pendv = 0;
        end
        if (left) m_last_l = e; else m_last_r = e;

        tag = pk ? "R5" : (cfg_mono ? "R6" : (urun ? "R8" : "R3"));
        if (!cfg_master) tag = {tag, "/R10"};
        tag = {tag, cfg_lj ? "/R2" : "/R1"};
        got  = (nbits >= ln) ? ((bits >> (nbits - ln)) & mk(ln)) : 64'hDEAD;
        tail = (nbits >= ln) ? (bits & mk(nbits - ln)) : 64'h1;
        chk(got == 64'(e), tag, left ? "left sample" : "right sample", got, e);
        chk(tail == 0, "R3", "padding after LSB", tail, 0);
        chk(nbits == slot_width, "R4", "slot width", nbits, slot_width);
        if (cfg_master)
            chk(period == 2 * int'(cfg_half), "R9", "bit clock period", period,
                2 * int'(cfg_half));
        slots_done++;
    endtask

    // Feeder and receiver, ordered within one process.
    always @(negedge clk) begin
        if (active && rst_n) begin
            if (in_valid && rdy_last) begin
                wq.push_back(in_data);
                fed++;
                in_valid = 1'b0;
            end
            if (!in_valid && fed < k_words) begin
                in_valid = 1'b1;
                in_data  = word_of(fed + 16 * slots_done);
            end
            if (ur_flag && !ur_seen) begin
                ur_seen  = 1;
                ur_first = ur_chan;
            end
            if (ur_flag) begin
                ur_flag_seen = 1;
                flag_run++;
                if (flag_run > flag_run_max) flag_run_max = flag_run;
            end else flag_run = 0;
            cyc_since++;
            if (bclk_o && !bprev) begin
                bit lvl;
                lvl = cfg_lj ? ws_o : ws_hist;
                ws_hist = ws_o;
                if (lvl != cur_lvl) begin
                    if (started) finish_slot(cur_lvl);
                    started = 1;
                    cur_lvl = lvl;
                    nbits = 0;
                    bits = '0;
                end
                if (started && nbits < 64) begin
                    bits = {bits[62:0], sd_o};
                    nbits++;
                end
                period = cyc_since;
                cyc_since = 0;
            end
            bprev = bclk_o;
        end
        rdy_last = in_ready;
    end

    // External clock source for slave runs: half period 6 system clocks.
    always @(posedge clk) begin
        if (active && rst_n && !cfg_master) begin
            if (ecnt == 5) begin
                ecnt <= 0;
                ext_bclk <= ~ext_bclk;
                if (ext_bclk) begin
                    if (ebit == slot_width - 1) begin
                        ebit <= 0;
                        ext_ws <= ~ext_ws;
                    end else ebit <= ebit + 1;
                end
            end else ecnt <= ecnt + 1;
        end
    end

    task automatic run_phase(input bit m, input bit lj, input logic [2:0] code,
                             input bit mono, input bit rep, input bit s32,
                             input int half, input int k, input int ns,
                             input bit clr);
        rst_n = 1'b0;
        active = 0;
        cfg_master = m; cfg_lj = lj; cfg_len = code; cfg_mono = mono;
        cfg_repeat = rep; cfg_slot32 = s32; cfg_half = 8'(half); ur_clr = clr;
        in_valid = 1'b0;
        wq.delete();
        m_last_l = 0; m_last_r = 0; m_pend = 0; m_pendv = 0;
        exp_ur_seen = 0; ur_seen = 0; ur_flag_seen = 0;
        flag_run = 0; flag_run_max = 0;
        fed = 0; k_words = k; slots_done = 0;
        slot_width = s32 ? 32 : mlen(code);
        ecnt = 0; ebit = 0; ext_bclk = 1'b0; ext_ws = ~lj;
        bprev = 0; ws_hist = ~lj; cur_lvl = ~lj; started = 0;
        cyc_since = 0; period = 0; nbits = 0; bits = '0;
        repeat (4) @(negedge clk);
        // R11 reset state: empty holding word, no flags, quiet line
        chk(in_ready == 1'b1, "R11", "in_ready in reset", in_ready, 1);
        chk(ur_flag == 1'b0 && ur_chan == 2'b00, "R7", "flags in reset",
            {ur_flag, ur_chan}, 0);
        chk(sd_o == 1'b0, "R3", "line in reset", sd_o, 0);
        active = 1;
        rst_n = 1'b1;
        while (slots_done < ns && !wd_hit) @(negedge clk);
        if (exp_ur_seen)
            chk(ur_seen && ur_first == exp_ur_first, "R7", "first underrun channel",
                ur_first, exp_ur_first);
        if (clr) begin
            chk(ur_flag_seen == 1, "R7", "set beats clear", ur_flag_seen, 1);
            chk(flag_run_max == 1, "R7", "clear drops flag next cycle",
                flag_run_max, 1);
        end else if (exp_ur_seen) begin
            chk(ur_flag == 1'b1, "R7", "flag sticky", ur_flag, 1);
        end
        active = 0;
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        wd_hit = 1;
    end

    initial begin
        // m lj code mono rep s32 half k ns clr
        run_phase(1, 0, 3'd0, 0, 0, 0, 2, 6, 8, 0);  // R1 32-bit, zeros on underrun
        run_phase(1, 1, 3'd4, 0, 1, 1, 2, 3, 6, 0);  // R2 R4 16 in 32, repeat
        run_phase(1, 0, 3'd5, 0, 1, 0, 3, 3, 8, 0);  // R5 packed 16
        run_phase(1, 1, 3'd6, 1, 0, 0, 2, 3, 8, 1);  // R6 mono 8, clear held
        run_phase(0, 0, 3'd3, 0, 0, 1, 2, 4, 8, 0);  // R10 slave, 18 in 32
        run_phase(1, 1, 3'd7, 0, 1, 1, 2, 2, 6, 0);  // R5 packed 8 in 32
        run_phase(1, 0, 3'd1, 0, 0, 0, 2, 4, 4, 0);  // R3 24-bit
        run_phase(1, 1, 3'd2, 0, 1, 0, 4, 4, 6, 0);  // R3 20-bit, R8 repeat
        if (wd_hit) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
        end
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule